// File: doc/BRIEF.md
# Block-Clear Instruction Sequencer

This block is the hardwired execute sequence for one application-specific instruction on a single-bus datapath. The instruction fills a run of consecutive byte locations with zero. A start pulse marks the end of the usual instruction fetch. It carries two operands: a count register, called R0, and an address register, called R1. The sequencer first clears its data register by ANDing it with the constant zero. It then loops over a memory write that waits for completion. Each completed write advances R1 by one and reduces R0 by one. The loop exits when the reduced count reaches zero, and a one-cycle done pulse is raised at that point.

Both registers stay visible after the instruction. R0 reads zero. R1 points one byte past the cleared run. The memory port is a plain request/acknowledge write port. The request and the address stay put until the acknowledge arrives, so a slow memory simply stretches the loop.

Top module: `blkclr_seq`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all 0.
- R2: A `start` seen while idle loads R0 with `count_in[6:0]` (the upper bits read as zero) and loads R1 with `addr_in`. `busy` is 1 in the next cycle.
- R3: Every write presented on the port carries data 0x00, because the data register is cleared before the loop.
- R4: While `mem_req` is 1 and `mem_ack` is 0, the request stays high and `mem_addr` stays unchanged. Each accepted write (`mem_req` and `mem_ack` both 1 at a clock edge) leaves R1 one above the address that was just written.
- R5: The number of accepted writes equals `count_in[6:0]`. Bits 15..7 of `count_in` have no effect.
- R6: `done` is high for exactly one cycle, in the cycle that follows the final accepted write, and `busy` is 0 in that same cycle. With a count n and an acknowledge latency of L wait cycles per write, `done` is visible 2 + n·(L+1) cycles after the start cycle.
- R7: At completion, R0 reads 0 and R1 reads start address + n (modulo 2^16).
- R8: A count of zero produces no write. `done` then pulses two cycles after the start cycle.
- R9: A `start` that arrives while `busy` is 1 is ignored. The operands of the instruction already in progress are kept.
- R10: Write addresses cover exactly start address through start address + n − 1, and they wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution (end of fetch) |
| count_in | input | 16 | Count operand; only bits 6..0 are used |
| addr_in | input | 16 | First byte address |
| mem_ack | input | 1 | Memory write complete |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | 16 | Write byte address |
| mem_wdata | output | 8 | Write data |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| r0_out | output | 16 | Current count register |
| r1_out | output | 16 | Current address register |

## Verification
Two events can land on the same clock edge. One is the final write acknowledge, which also performs the zero-count exit. The other is a new `start` arriving while the instruction is still running. The bench sweeps every count from 0 to 127 at acknowledge latencies of 0, 1 and 2 cycles. On alternate runs it injects a second `start` with different operands during the busy window. Each run is judged on the write count, the address of every write, the exact cycle of the `done` pulse, and the final register values; all of these are computed arithmetically from the first operands.

// File: rtl/blkclr_seq.sv
module blkclr_seq #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] count_in,
  input  logic [AW-1:0] addr_in,
  input  logic          mem_ack,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] r0_out,
  output logic [AW-1:0] r1_out
);
  typedef enum logic [1:0] {S_IDLE, S_CLR, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] r0, r1;
  logic [DW-1:0] mdr;
  logic          dn;

  wire last_one = (r0 == AW'(1));
  wire cnt_zero = (r0 == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      r0  <= '0;
      r1  <= '0;
      mdr <= '1;
      dn  <= 1'b0;
    end else begin
      dn <= 1'b0;
      case (st)
        S_IDLE:
          if (start) begin
            r0 <= AW'(count_in[CW-1:0]);
            r1 <= addr_in;
            st <= S_CLR;
          end
        S_CLR: begin
          mdr <= mdr & '0;
          if (cnt_zero) begin
            st <= S_IDLE;
            dn <= 1'b1;
          end else begin
            st <= S_WR;
          end
        end
        S_WR:
          if (mem_ack) begin
            r1 <= r1 + AW'(1);
            r0 <= r0 - AW'(1);
            if (last_one) begin
              st <= S_IDLE;
              dn <= 1'b1;
            end
          end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_WR);
  assign mem_addr  = r1;
  assign mem_wdata = mdr;
  assign busy      = (st != S_IDLE);
  assign done      = dn;
  assign r0_out    = r0;
  assign r1_out    = r1;
endmodule

// File: rtl/blkclr_seq_chk.sv
module blkclr_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [AW-1:0] addr_in,
  input logic          mem_ack,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          busy,
  input logic          done,
  input logic [AW-1:0] r1_out
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && r1_out == $past(addr_in)));
  a_r3_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_wdata == '0));
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (r1_out == $past(mem_addr) + AW'(1)));
  a_r6_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r9_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(mem_req && mem_ack)) |=> $stable(r1_out));
endmodule

bind blkclr_seq blkclr_seq_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
  .mem_ack(mem_ack), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .busy(busy), .done(done), .r1_out(r1_out)
);

// File: tb/blkclr_seq_tb.sv
module blkclr_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] count_in = '0;
  logic [15:0] addr_in = '0;
  logic        mem_ack = 1'b0;
  logic        mem_req, busy, done;
  logic [15:0] mem_addr, r0_out, r1_out;
  logic [7:0]  mem_wdata;

  int checks = 0;
  int fails = 0;
  int lat = 0;
  int wcnt = 0;
  int wr_idx = 0;
  int total_cyc = 0;
  logic [15:0] exp_base = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkclr_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .count_in(count_in),
    .addr_in(addr_in), .mem_ack(mem_ack), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy),
    .done(done), .r0_out(r0_out), .r1_out(r1_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req) begin
      if (wcnt == lat) begin
        mem_ack = 1'b1;
        wcnt = 0;
      end else begin
        mem_ack = 1'b0;
        wcnt++;
      end
    end else begin
      mem_ack = 1'b0;
      wcnt = 0;
    end
    if (mem_req && mem_ack) begin
      chk(mem_addr == 16'(exp_base + 16'(wr_idx)), "R4/R10 write address",
          int'(mem_addr), int'(16'(exp_base + 16'(wr_idx))));
      chk(mem_wdata == 8'h00, "R3 write data", int'(mem_wdata), 0);
      wr_idx++;
    end
  end

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc == 190000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", total_cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic run(input logic [15:0] base, input logic [15:0] cnt,
                     input int l, input bit inject);
    int n = int'(cnt[6:0]);
    int cyc = 0;
    bit seen = 1'b0;
    lat = l;
    exp_base = base;
    wr_idx = 0;
    @(negedge clk);
    start = 1'b1;
    count_in = cnt;
    addr_in = base;
    while (!seen && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1 && inject) begin
        start = 1'b1;
        count_in = ~cnt;
        addr_in = base ^ 16'h5a5a;
      end else begin
        start = 1'b0;
      end
      if (done) seen = 1'b1;
    end
    start = 1'b0;
    chk(seen && cyc == 2 + n * (l + 1), n == 0 ? "R8 done timing" : "R6 done timing",
        cyc, 2 + n * (l + 1));
    chk(wr_idx == n, n == 0 ? "R8 no writes" : (inject ? "R9/R5 write count" : "R5 write count"),
        wr_idx, n);
    chk(r0_out == 16'h0, "R7 final count", int'(r0_out), 0);
    chk(r1_out == 16'(base + 16'(n)), inject ? "R9/R7 final address" : "R7 final address",
        int'(r1_out), int'(16'(base + 16'(n))));
    chk(!busy, "R6 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(!done, "R6 done width", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_req, "R1 reset state", int'({busy, done, mem_req}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy, "R1 idle after reset", int'(busy), 0);
    @(negedge clk);
    start = 1'b1;
    count_in = 16'd5;
    addr_in = 16'h1234;
    @(negedge clk);
    start = 1'b0;
    chk(busy && r1_out == 16'h1234 && r0_out == 16'd5, "R2 operand load",
        int'(r1_out), 16'h1234);
    lat = 0;
    exp_base = 16'h1234;
    wr_idx = 0;
    while (!done) @(negedge clk);
    @(negedge clk);
    for (int n = 0; n < 128; n++) begin
      for (int l = 0; l < 3; l++) begin
        run(16'(n * 613 + l * 4099), 16'(n) | 16'((n * 3 + l + 1) << 7), l, ((n + l) % 2) == 1);
      end
    end
    run(16'hFFF0, 16'd127, 1, 1'b0);
    run(16'hFFFF, 16'hFF81, 0, 1'b1);
    run(16'hFFFF, 16'h0002, 2, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule